// File: doc/BRIEF.md
# Flash Line Prefetch Buffer Controller

This block sits between a 64-bit system read port and a flash array read port that returns 128-bit lines at a fixed latency. It keeps a small, fully associative store of recently read lines. A request whose line is resident is answered in the same cycle it is presented, so it costs no wait states. A request that misses starts one array read. The returned line is written into the store, and the request is answered from the store in the following cycle.

Instruction fetches can also arm a sequential prefetch. Once a fetch has been served, the next line of the array is read in the background. This happens only when a prefetch enable is high, when that next line is not already resident, and when the fetched line is not the last line of the array. Data loads and DMA reads share the same port but never arm a prefetch.

Only one array read is outstanding at any time, and a demand miss is always issued before a pending prefetch. A demand that wants the line already being read waits for that read to finish rather than issuing a second one. Replacement picks an empty entry first and otherwise the least recently used entry. An invalidate input empties the whole store in a single cycle.

Top module: `flash_prefetch_buf`

## Requirements
- R1: After reset no line is resident and neither rspValid nor arrRdEn is high while reqValid is low; the first request after reset misses.
- R2: A request whose line is resident gets rspValid in the same cycle that reqValid is first presented (zero wait states).
- R3: A request that misses while no array read is outstanding raises arrRdEn in that same cycle with arrRdLine equal to the upper address bits reqAddr[ADDR_W-1:1]; with an array that answers two cycles after arrRdEn, rspValid follows after exactly three wait states.
- R4: reqAddr is a 64-bit beat address. Bit 0 selects the beat: 1 returns line bits [127:64] and 0 returns bits [63:0].
- R5: When an instruction fetch (reqKind 2'b10) is served with pfEn high, the next sequential line is read in the background once the array is free, and a later request for that line hits.
- R6: Served data loads (reqKind 2'b00) and DMA reads (reqKind 2'b01) never start a prefetch read.
- R7: With pfEn low, a served instruction fetch starts no prefetch read.
- R8: An instruction fetch that is served from the last array line (ARRAY_LINES-1) starts no prefetch read.
- R9: A fill goes into an empty entry if there is one and otherwise replaces the least recently used entry, where both fills and hits count as uses.
- R10: A demand request for the line that is currently being read issues no second array read. It is served in the cycle after that read's data returns.
- R11: At most one array read is outstanding. A demand miss is issued before a pending prefetch, and the prefetch follows once the array is free.
- R12: A one-cycle pulse on inval clears every resident line, so the next request to any line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request present; held with stable address and kind until rspValid |
| reqAddr | input | ADDR_W | Beat (8-byte) address; bit 0 selects the half line |
| reqKind | input | 2 | 00 data load, 01 DMA read, 10 instruction fetch |
| rspValid | output | 1 | Read data valid; completes the request this cycle |
| rspData | output | BEAT_BITS | Selected 64-bit beat |
| pfEn | input | 1 | Allows sequential prefetch on instruction fetches |
| inval | input | 1 | Clears all resident lines |
| arrRdEn | output | 1 | Array read strobe, one cycle |
| arrRdLine | output | LINE_W | Line index of the array read |
| arrRdValid | input | 1 | Array read data valid |
| arrRdData | input | 2*BEAT_BITS | Array line data |

## Verification
The bench builds the block with four entries and an array of only sixteen lines. This keeps the last-line boundary of R8 within a few requests, and it lets a run of five distinct lines force an eviction for the LRU check. The bench's array model answers two cycles after each strobe, which pins a miss at three wait states and an overlapping prefetch at two. It also logs the order of array reads, so duplicate reads and miss-before-prefetch ordering are seen directly on the array port.

// File: rtl/fpb_pkg.sv
package fpb_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD   = 2'b00,
    KIND_DMA    = 2'b01,
    KIND_IFETCH = 2'b10
  } reqKind_e;

  // strobes from the sequencer to the line store
  typedef struct packed {
    logic fillWr;    // write returned array line into the victim entry
    logic touchHit;  // a hit was served: mark its entry most recent
  } ctrlStrobe_t;

endpackage

// File: rtl/fpb_datapath.sv
module fpb_datapath
  import fpb_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int LINE_W      = 12,
  parameter int BEAT_BITS   = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic                   inval,
  input  logic [LINE_W-1:0]      reqLine,
  input  logic                   reqBeatHi,
  input  logic [LINE_W-1:0]      pfLine,
  input  logic [LINE_W-1:0]      fillLine,
  input  logic [2*BEAT_BITS-1:0] fillData,
  output logic                   reqHit,
  output logic [BEAT_BITS-1:0]   reqData,
  output logic                   pfHit
);

  localparam int LINE_BITS = 2 * BEAT_BITS;
  localparam int IDX_W     = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [LINE_W-1:0]    tagQ  [NUM_ENTRIES];
  logic [LINE_BITS-1:0] dataQ [NUM_ENTRIES];
  logic [IDX_W-1:0]     ageQ  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] validQ;

  logic [NUM_ENTRIES-1:0] reqMatch, pfMatch;
  logic [IDX_W-1:0] hitIdx, victimIdx, touchIdx;
  logic touchEn;
  logic foundFree;
  logic [LINE_BITS-1:0] hitLine;

  genvar g;
  generate
    for (g = 0; g < NUM_ENTRIES; g++) begin : gCmp
      assign reqMatch[g] = validQ[g] && (tagQ[g] == reqLine);
      assign pfMatch[g]  = validQ[g] && (tagQ[g] == pfLine);
    end
  endgenerate

  assign reqHit = |reqMatch;
  assign pfHit  = |pfMatch;

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (reqMatch[i]) hitIdx = IDX_W'(i);
  end

  assign hitLine = dataQ[hitIdx];
  assign reqData = reqBeatHi ? hitLine[BEAT_BITS +: BEAT_BITS] : hitLine[0 +: BEAT_BITS];

  // victim: lowest empty entry, otherwise the oldest
  always_comb begin
    victimIdx = '0;
    foundFree = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (!validQ[i] && !foundFree) begin
        victimIdx = IDX_W'(i);
        foundFree = 1'b1;
      end
    if (!foundFree)
      for (int i = 0; i < NUM_ENTRIES; i++)
        if (ageQ[i] == IDX_W'(NUM_ENTRIES - 1)) victimIdx = IDX_W'(i);
  end

  // a fill in the same cycle as a hit takes the recency update
  assign touchEn  = strobe.fillWr || strobe.touchHit;
  assign touchIdx = strobe.fillWr ? victimIdx : hitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        tagQ[i]  <= '0;
        dataQ[i] <= '0;
        ageQ[i]  <= IDX_W'(i);
      end
    end else begin
      if (inval) begin
        validQ <= '0;
      end else if (strobe.fillWr) begin
        validQ[victimIdx] <= 1'b1;
        tagQ[victimIdx]   <= fillLine;
        dataQ[victimIdx]  <= fillData;
      end
      if (touchEn)
        for (int i = 0; i < NUM_ENTRIES; i++) begin
          if (IDX_W'(i) == touchIdx)       ageQ[i] <= '0;
          else if (ageQ[i] < ageQ[touchIdx]) ageQ[i] <= ageQ[i] + 1'b1;
        end
    end
  end

  // ---- assertions ----
  logic [NUM_ENTRIES-1:0] ageSeen;
  always_comb begin
    ageSeen = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      ageSeen[ageQ[i]] = 1'b1;
  end

  // R9: recency ranks stay a permutation, so exactly one entry is oldest
  a_r9_age_permutation: assert property (@(posedge clk) disable iff (!rstN)
    &ageSeen);

  // R12: invalidate leaves nothing resident
  a_r12_inval_clears: assert property (@(posedge clk) disable iff (!rstN)
    inval |=> (validQ == '0));

  // R9: a written line is resident in the chosen victim afterwards
  a_r9_fill_lands: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillWr && !inval) |=> (validQ[$past(victimIdx)] && tagQ[$past(victimIdx)] == $past(fillLine)));

endmodule

// File: rtl/fpb_control.sv
module fpb_control
  import fpb_pkg::*;
#(
  parameter int LINE_W      = 12,
  parameter int ARRAY_LINES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              reqHit,
  input  logic              pfHit,
  input  logic              pfEn,
  input  logic              inval,
  input  logic              arrRdValid,
  output logic              rspValid,
  output logic              arrRdEn,
  output logic [LINE_W-1:0] arrRdLine,
  output logic [LINE_W-1:0] fillLine,
  output logic [LINE_W-1:0] pfLine,
  output ctrlStrobe_t       strobe
);

  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(ARRAY_LINES - 1);

  logic busyQ, discardQ, pfPendQ;
  logic [LINE_W-1:0] flightLineQ, pfLineQ;
  logic demandMiss, issueDemand, issuePf, pfSet, pfDrop;

  assign demandMiss  = reqValid && !reqHit;
  assign issueDemand = demandMiss && !busyQ;
  assign issuePf     = !busyQ && !demandMiss && pfPendQ && pfEn && !pfHit;
  assign pfDrop      = pfPendQ && !busyQ && pfHit;

  assign arrRdEn   = issueDemand || issuePf;
  assign arrRdLine = issueDemand ? reqLine : pfLineQ;
  assign fillLine  = flightLineQ;
  assign pfLine    = pfLineQ;

  assign rspValid = reqValid && reqHit;
  assign pfSet    = rspValid && (reqKind == KIND_IFETCH) && pfEn && (reqLine != LAST_LINE);

  assign strobe.fillWr   = arrRdValid && !discardQ && !inval;
  assign strobe.touchHit = rspValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ       <= 1'b0;
      discardQ    <= 1'b0;
      flightLineQ <= '0;
      pfPendQ     <= 1'b0;
      pfLineQ     <= '0;
    end else begin
      if (arrRdEn) begin
        busyQ       <= 1'b1;
        flightLineQ <= arrRdLine;
        discardQ    <= 1'b0;
      end else begin
        if (arrRdValid)     busyQ    <= 1'b0;
        if (inval && busyQ) discardQ <= 1'b1;
      end
      if (pfSet) begin
        pfPendQ <= 1'b1;
        pfLineQ <= reqLine + 1'b1;
      end else if (issuePf || pfDrop) begin
        pfPendQ <= 1'b0;
      end
    end
  end

  // ---- assertions ----
  // R11: a read strobe is never followed directly by another
  a_r11_single_read: assert property (@(posedge clk) disable iff (!rstN)
    arrRdEn |=> !arrRdEn);

  // R11: array data only returns for an outstanding read
  a_r11_data_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    arrRdValid |-> busyQ);

  // R6: served loads and DMA reads do not arm a prefetch
  a_r6_no_pf_from_data: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && reqKind != KIND_IFETCH && !pfPendQ) |=> !pfPendQ);

  // R10: waiting on the in-flight line issues no duplicate read
  a_r10_no_duplicate: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && reqValid && reqLine == flightLineQ && !discardQ && !inval) |=> !(arrRdEn && arrRdLine == $past(flightLineQ)));

endmodule

// File: rtl/flash_prefetch_buf.sv
module flash_prefetch_buf
  import fpb_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ARRAY_LINES = 4096,
  parameter int BEAT_BITS   = 64,
  localparam int LINE_W     = $clog2(ARRAY_LINES),
  localparam int ADDR_W     = LINE_W + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [1:0]             reqKind,
  output logic                   rspValid,
  output logic [BEAT_BITS-1:0]   rspData,
  input  logic                   pfEn,
  input  logic                   inval,
  output logic                   arrRdEn,
  output logic [LINE_W-1:0]      arrRdLine,
  input  logic                   arrRdValid,
  input  logic [2*BEAT_BITS-1:0] arrRdData
);

  ctrlStrobe_t strobe;
  logic reqHit, pfHit;
  logic [LINE_W-1:0] reqLine, fillLine, pfLine;

  assign reqLine = reqAddr[ADDR_W-1:1];

  fpb_control #(.LINE_W(LINE_W), .ARRAY_LINES(ARRAY_LINES)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqLine(reqLine), .reqHit(reqHit), .pfHit(pfHit), .pfEn(pfEn),
    .inval(inval), .arrRdValid(arrRdValid), .rspValid(rspValid),
    .arrRdEn(arrRdEn), .arrRdLine(arrRdLine), .fillLine(fillLine),
    .pfLine(pfLine), .strobe(strobe)
  );

  fpb_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .LINE_W(LINE_W), .BEAT_BITS(BEAT_BITS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inval(inval),
    .reqLine(reqLine), .reqBeatHi(reqAddr[0]), .pfLine(pfLine),
    .fillLine(fillLine), .fillData(arrRdData), .reqHit(reqHit),
    .reqData(rspData), .pfHit(pfHit)
  );

endmodule

// File: tb/flash_prefetch_buf_test.sv
module flash_prefetch_buf_test;

  localparam int LINES  = 16;
  localparam int LINE_W = $clog2(LINES);
  localparam int ADDR_W = LINE_W + 1;
  localparam int LAT    = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0] reqKind = 2'b00;
  logic pfEn = 1'b0;
  logic inval = 1'b0;
  logic rspValid, arrRdEn, arrRdValid;
  logic [63:0] rspData;
  logic [LINE_W-1:0] arrRdLine;
  logic [127:0] arrRdData;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_prefetch_buf #(.NUM_ENTRIES(4), .ARRAY_LINES(LINES), .BEAT_BITS(64)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .rspValid(rspValid), .rspData(rspData),
    .pfEn(pfEn), .inval(inval), .arrRdEn(arrRdEn), .arrRdLine(arrRdLine),
    .arrRdValid(arrRdValid), .arrRdData(arrRdData)
  );

  function automatic logic [127:0] lineData(input int n);
    logic [127:0] d;
    for (int k = 0; k < 4; k++) d[32*k +: 32] = {16'hF1A5, 12'(n), 4'(k)};
    return d;
  endfunction

  // array model: data two cycles after the strobe; logs read order
  logic [LAT-1:0] pV;
  logic [LINE_W-1:0] pL [LAT];
  int rdCount = 0;
  int rdLog [32];

  always @(posedge clk) begin
    if (!rstN) begin
      pV <= '0;
    end else begin
      pV <= {pV[LAT-2:0], arrRdEn};
      pL[0] <= arrRdLine;
      for (int k = 1; k < LAT; k++) pL[k] <= pL[k-1];
      if (arrRdEn) begin
        rdLog[rdCount % 32] <= int'(arrRdLine);
        rdCount <= rdCount + 1;
      end
    end
  end
  assign arrRdValid = pV[LAT-1];
  assign arrRdData  = lineData(int'(pL[LAT-1]));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearAll();
    inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
  endtask

  // one bus request; starts and ends on a falling edge
  task automatic doReq(input int beat, input logic [1:0] kind, input int expWait, input string tag);
    int w;
    logic [127:0] ld;
    logic [63:0] expData;
    ld = lineData(beat / 2);
    expData = (beat % 2 == 1) ? ld[127:64] : ld[63:0];
    reqValid = 1'b1;
    reqAddr = ADDR_W'(beat);
    reqKind = kind;
    #1;
    w = 0;
    while (!rspValid && w < 40) begin
      @(negedge clk);
      #1;
      w++;
    end
    check(w == expWait, {tag, " wait states"}, w, expWait);
    check(rspData == expData, {tag, " data"}, rspData, expData);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic tReset();
    #1;
    check(rspValid == 1'b0, "R1 rspValid idle after reset", rspValid, 0);
    check(arrRdEn == 1'b0, "R1 arrRdEn idle after reset", arrRdEn, 0);
    @(negedge clk);
    doReq(5, 2'b00, 3, "R1 first request misses");
  endtask

  task automatic tMissAndHit();
    int base;
    base = rdCount;
    reqValid = 1'b1; reqAddr = ADDR_W'(6); reqKind = 2'b00;
    #1;
    check(arrRdEn == 1'b1, "R3 strobe in miss cycle", arrRdEn, 1);
    check(arrRdLine == 3, "R3 read line index", arrRdLine, 3);
    @(negedge clk);
    reqValid = 1'b0;
    idle(4);
    doReq(6, 2'b00, 0, "R2 hit lower beat");
    doReq(7, 2'b01, 0, "R4 hit upper beat");
    doReq(9, 2'b00, 3, "R3 miss three waits");
    doReq(8, 2'b00, 0, "R4 lower beat of new line");
    check(rdCount - base == 2, "R3 read count", rdCount - base, 2);
  endtask

  task automatic tDataNoPf();
    int base;
    clearAll();
    pfEn = 1'b1;
    base = rdCount;
    doReq(10, 2'b00, 3, "R6 load line 5");
    doReq(12, 2'b01, 3, "R6 dma line 6");
    idle(4);
    check(rdCount - base == 2, "R6 no prefetch reads", rdCount - base, 2);
    doReq(14, 2'b00, 3, "R6 line 7 not prefetched");
  endtask

  task automatic tIfetchPf();
    int base;
    clearAll();
    pfEn = 1'b1;
    base = rdCount;
    doReq(6, 2'b10, 3, "R5 fetch line 3");
    idle(5);
    check(rdCount - base == 2, "R5 one prefetch read", rdCount - base, 2);
    check(rdLog[(base + 1) % 32] == 4, "R5 prefetch line", rdLog[(base + 1) % 32], 4);
    doReq(8, 2'b00, 0, "R5 prefetched line hits");
  endtask

  task automatic tPfDisabled();
    int base;
    clearAll();
    idle(4);
    pfEn = 1'b0;
    base = rdCount;
    doReq(16, 2'b10, 3, "R7 fetch line 8");
    idle(4);
    check(rdCount - base == 1, "R7 no prefetch", rdCount - base, 1);
    doReq(18, 2'b10, 3, "R7 line 9 misses");
  endtask

  task automatic tTopLine();
    int base;
    clearAll();
    idle(4);
    pfEn = 1'b1;
    base = rdCount;
    doReq(30, 2'b10, 3, "R8 fetch last line");
    idle(4);
    check(rdCount - base == 1, "R8 no wrap prefetch", rdCount - base, 1);
  endtask

  task automatic tInflight();
    int base;
    clearAll();
    idle(4);
    pfEn = 1'b1;
    base = rdCount;
    doReq(20, 2'b10, 3, "R10 fetch line 10");
    idle(1);
    doReq(22, 2'b10, 2, "R10 wait on in-flight line");
    idle(3);
    check(rdLog[(base + 1) % 32] == 11, "R10 second read", rdLog[(base + 1) % 32], 11);
    check(rdLog[(base + 2) % 32] == 12, "R10 third read", rdLog[(base + 2) % 32], 12);
    check(rdCount - base == 3, "R10 no duplicate read", rdCount - base, 3);
  endtask

  task automatic tPriority();
    int base;
    clearAll();
    idle(4);
    pfEn = 1'b1;
    base = rdCount;
    doReq(2, 2'b10, 3, "R11 fetch line 1");
    doReq(12, 2'b00, 3, "R11 demand before prefetch");
    idle(4);
    check(rdLog[(base + 1) % 32] == 6, "R11 demand issued first", rdLog[(base + 1) % 32], 6);
    check(rdLog[(base + 2) % 32] == 2, "R11 prefetch issued after", rdLog[(base + 2) % 32], 2);
    doReq(4, 2'b00, 0, "R11 prefetched line hits");
  endtask

  task automatic tLru();
    clearAll();
    idle(4);
    pfEn = 1'b0;
    for (int n = 0; n < 4; n++) doReq(2 * n, 2'b00, 3, "R9 fill");
    doReq(1, 2'b00, 0, "R9 touch line 0");
    doReq(8, 2'b00, 3, "R9 fifth line");
    doReq(0, 2'b00, 0, "R9 line 0 kept");
    doReq(4, 2'b00, 0, "R9 line 2 kept");
    doReq(6, 2'b00, 0, "R9 line 3 kept");
    doReq(2, 2'b00, 3, "R9 line 1 evicted");
  endtask

  task automatic tInval();
    doReq(6, 2'b00, 0, "R12 resident before clear");
    clearAll();
    doReq(6, 2'b00, 3, "R12 miss after clear");
    doReq(2, 2'b01, 3, "R12 other line misses");
  endtask

  task automatic finish();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tMissAndHit();
    tDataNoPf();
    tIfetchPf();
    tPfDisabled();
    tTopLine();
    tInflight();
    tPriority();
    tLru();
    tInval();
    idle(2);
    finished = 1'b1;
    finish();
  end

endmodule